// File: doc/BRIEF.md
# Crossbar Lane Permutation Unit

This execution unit sits in an integer pipeline and performs a table-lookup permutation on register data. The first operand is treated as a table of equal-width elements. Each element of the second operand is an index into that table. The result element in the same lane is the table entry that the index selects. Two element widths are supported, 4-bit and 8-bit. The width is chosen by decoding a 32-bit R-type instruction word.

The pipeline presents the instruction word, both XLEN-wide operands, an extension-enable bit and a valid strobe. One cycle later the unit returns a registered result, a valid flag and an illegal flag. An index that points past the end of the register produces a zero element; it never wraps. XLEN is a parameter and may be 32 or 64.

Top module: `xbar_perm_unit`

## Requirements
- R1: With the 4-bit encoding, every 4-bit lane i of the result equals 4-bit element k of src_a, where k is the value of lane i of src_b, whenever k*4 < XLEN.
- R2: With the 8-bit encoding, every byte lane i of the result equals byte k of src_a, where k is byte i of src_b, whenever k*8 < XLEN.
- R3: A result element whose index times the element width is XLEN or more is zero. For example, with 4-bit elements and XLEN=32, indices 8 to 15 give zero.
- R4: The instruction is legal only when all of these hold: bits [6:0] = 0110011, bits [31:25] = 0010100, and bits [14:12] = 010 (4-bit) or 100 (8-bit). All other words are illegal. The register fields in bits [24:15] and [11:7] have no effect.
- R5: While ext_en is low, both encodings are reported as illegal.
- R6: An accepted illegal word gives out_illegal = 1 and out_result = 0.
- R7: out_valid is high exactly in the cycle after a cycle with in_valid high. In a cycle where out_valid is low, out_result and out_illegal are zero.
- R8: A synchronous active-high rst clears out_valid, out_illegal and out_result at the next edge. This holds even when in_valid is high at the same time.
- R9: All XLEN bits of both operands take part. With XLEN=64, the upper 32 bits are selected and placed exactly like the lower ones, with no sign or zero extension.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| ext_en | input | 1 | Enables the two permutation encodings |
| insn | input | 32 | Instruction word |
| src_a | input | XLEN | Lookup table operand |
| src_b | input | XLEN | Index operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_illegal | output | 1 | Accepted word was not a legal permutation |
| out_result | output | XLEN | Permuted result, or zero |

## Verification
The unit holds its state in a single register stage, so a wrong value shows at the ports in the first cycle after the strobe. Every check samples exactly that cycle. A lane selector that wraps an index, or that reads the wrong element, corrupts a specific result lane. The reference model and the out-of-range vectors isolate such a fault to that lane. A wrong decode shows in the same cycle as a flipped out_illegal together with a non-zero result. A stale pipeline register shows as a result or illegal flag that is still non-zero in an idle cycle.

// File: rtl/xbar_perm_pkg.sv
package xbar_perm_pkg;

    typedef enum logic [1:0] {
        OPK_NONE = 2'd0,
        OPK_NIB  = 2'd1,
        OPK_BYTE = 2'd2
    } opk_e;

    // field mask covering funct7, funct3 and opcode
    localparam logic [31:0] ENC_MASK     = 32'hFE00_707F;
    localparam logic [31:0] ENC_NIB_PAT  = 32'h2800_2033;
    localparam logic [31:0] ENC_BYTE_PAT = 32'h2800_4033;

endpackage

// File: rtl/xbar_perm_decode.sv
module xbar_perm_decode
    import xbar_perm_pkg::*;
(
    input  logic [31:0] insn,
    input  logic        ext_en,
    output opk_e        op
);
    logic [31:0] fields;

    always_comb begin
        fields = insn & ENC_MASK;
        op     = OPK_NONE;
        if (ext_en) begin
            if (fields == ENC_NIB_PAT) begin
                op = OPK_NIB;
            end else if (fields == ENC_BYTE_PAT) begin
                op = OPK_BYTE;
            end
        end
    end
endmodule

// File: rtl/xbar_lane_sel.sv
module xbar_lane_sel #(
    parameter int XLEN = 32,
    parameter int EW   = 4
) (
    input  logic [XLEN-1:0] table_i,
    input  logic [XLEN-1:0] index_i,
    output logic [XLEN-1:0] perm_o
);
    localparam int LANES = XLEN / EW;

    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        logic [EW-1:0] idx;
        logic [EW-1:0] pick;

        assign idx = index_i[gl*EW +: EW];

        // indices with no matching table slot leave pick at zero
        always_comb begin
            pick = '0;
            for (int k = 0; k < LANES; k++) begin
                if (idx == EW'(k)) begin
                    pick = table_i[k*EW +: EW];
                end
            end
        end

        assign perm_o[gl*EW +: EW] = pick;
    end
endmodule

// File: rtl/xbar_perm_unit.sv
module xbar_perm_unit
    import xbar_perm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            ext_en,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            out_valid,
    output logic            out_illegal,
    output logic [XLEN-1:0] out_result
);
    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [XLEN-1:0] result;
    } stage_t;

    opk_e            op;
    logic [XLEN-1:0] nib_res;
    logic [XLEN-1:0] byte_res;
    stage_t          stage_d;
    stage_t          stage_q;

    xbar_perm_decode u_dec (
        .insn   (insn),
        .ext_en (ext_en),
        .op     (op)
    );

    xbar_lane_sel #(.XLEN(XLEN), .EW(4)) u_nib (
        .table_i (src_a),
        .index_i (src_b),
        .perm_o  (nib_res)
    );

    xbar_lane_sel #(.XLEN(XLEN), .EW(8)) u_byte (
        .table_i (src_a),
        .index_i (src_b),
        .perm_o  (byte_res)
    );

    always_comb begin
        stage_d         = '0;
        stage_d.valid   = in_valid;
        if (in_valid) begin
            unique case (op)
                OPK_NIB:  stage_d.result = nib_res;
                OPK_BYTE: stage_d.result = byte_res;
                default:  stage_d.illegal = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid   = stage_q.valid;
    assign out_illegal = stage_q.illegal;
    assign out_result  = stage_q.result;
endmodule

// File: rtl/xbar_perm_chk.sv
module xbar_perm_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            ext_en,
    input logic [31:0]     insn,
    input logic [3:0]      b_low,
    input logic            out_valid,
    input logic            out_illegal,
    input logic [XLEN-1:0] out_result
);
    assert_wrong_opcode_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ((insn & 32'h0000_007F) != 32'h0000_0033)) |=> out_illegal);

    assert_disabled_illegal_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ext_en) |=> (out_valid && out_illegal));

    assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_result == '0));

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_clean_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && out_result == '0));

    assert_nib_range_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ext_en && ((insn & 32'hFE00_707F) == 32'h2800_2033)
         && (int'(b_low) * 4 >= XLEN)) |=> (out_result[3:0] == 4'h0));

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && out_result == '0));
endmodule

bind xbar_perm_unit xbar_perm_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .ext_en      (ext_en),
    .insn        (insn),
    .b_low       (src_b[3:0]),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_result  (out_result)
);

// File: tb/sim_xbar_perm_unit.sv
`timescale 1ns/1ps
module sim_xbar_perm_unit;

    localparam logic [31:0] I_NIB  = 32'h2800_2033;
    localparam logic [31:0] I_BYTE = 32'h2800_4033;
    localparam int NV = 8;

    // tag: 1 -> R1, 2 -> R2, 3 -> R3, 9 -> R9
    localparam logic [31:0] V_INSN [NV] = '{
        I_NIB, I_BYTE, I_NIB, I_BYTE, I_NIB, I_BYTE, I_NIB, I_BYTE };
    localparam logic [63:0] V_A [NV] = '{
        64'h0123_4567_89AB_CDEF, 64'h1122_3344_5566_7788,
        64'hDEAD_BEEF_CAFE_F00D, 64'hA5A5_5A5A_0F0F_F0F0,
        64'h3C1F_9A07_E2B4_6D58, 64'h9E37_79B9_7F4A_7C15,
        64'h8000_0000_0000_0000, 64'hFF00_0000_0000_00AA };
    localparam logic [63:0] V_B [NV] = '{
        64'hFEDC_BA98_7654_3210, 64'h0706_0504_0302_0100,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h4040_4040_4040_4040,
        64'h5F3A_0C91_7E26_B4D8, 64'h0307_0206_0905_0001,
        64'hF000_0000_0000_0000, 64'h0007_0000_0000_0000 };
    localparam int V_TAG [NV] = '{1, 2, 3, 3, 1, 2, 9, 9};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        ext_en = 1'b1;
    logic [31:0] insn = 32'h0;
    logic [63:0] a64 = '0;
    logic [63:0] b64 = '0;
    logic        v32, il32, v64, il64;
    logic [31:0] r32;
    logic [63:0] r64;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;

    always #2.5 clk = ~clk;

    xbar_perm_unit #(.XLEN(32)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ext_en(ext_en), .insn(insn),
        .src_a(a64[31:0]), .src_b(b64[31:0]),
        .out_valid(v32), .out_illegal(il32), .out_result(r32));

    xbar_perm_unit #(.XLEN(64)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ext_en(ext_en), .insn(insn),
        .src_a(a64), .src_b(b64),
        .out_valid(v64), .out_illegal(il64), .out_result(r64));

    function automatic logic [63:0] ref_perm(input int xlen, input int ew,
                                             input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r    = '0;
        logic [63:0] mask = (64'd1 << ew) - 64'd1;
        for (int i = 0; i < xlen; i += ew) begin
            int pos = int'((b >> i) & mask) * ew;
            if (pos < xlen) r |= ((a >> pos) & mask) << i;
        end
        if (xlen == 32) r[63:32] = '0;
        return r;
    endfunction

    function automatic int ref_ew(input logic [31:0] w, input logic en);
        if (!en) return 0;
        if ((w & 32'hFE00_707F) == I_NIB) return 4;
        if ((w & 32'hFE00_707F) == I_BYTE) return 8;
        return 0;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // drive one strobe and check both units in the cycle after it
    task automatic run_op(input string req, input logic [31:0] w, input logic en,
                          input logic [63:0] a, input logic [63:0] b);
        int          ew = ref_ew(w, en);
        logic [63:0] e32 = (ew == 0) ? 64'h0 : ref_perm(32, ew, a, b);
        logic [63:0] e64 = (ew == 0) ? 64'h0 : ref_perm(64, ew, a, b);
        @(negedge clk);
        insn = w; ext_en = en; a64 = a; b64 = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "valid32",   {63'h0, v32},  64'h1);
        check(req, "illegal32", {63'h0, il32}, {63'h0, ew == 0});
        check(req, "result32",  {32'h0, r32},  e32);
        check(req, "valid64",   {63'h0, v64},  64'h1);
        check(req, "illegal64", {63'h0, il64}, {63'h0, ew == 0});
        check(req, "result64",  r64,           e64);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        string tg;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8", "reset valid32",  {63'h0, v32}, 64'h0);
        check("R8", "reset result64", r64,          64'h0);
        check("R8", "reset illegal",  {62'h0, il32, il64}, 64'h0);
        rst = 1'b0;

        for (int n = 0; n < NV; n++) begin
            case (V_TAG[n])
                1:       tg = "R1";
                2:       tg = "R2";
                3:       tg = "R3";
                default: tg = "R9";
            endcase
            run_op(tg, V_INSN[n], 1'b1, V_A[n], V_B[n]);
        end

        // R3 byte index just past each width: 4 for XLEN=32, 8 for both
        run_op("R3", I_BYTE, 1'b1, 64'h8877_6655_4433_2211, 64'h0804_0800_0403_0201);
        // R4 register fields do not matter
        run_op("R4", I_NIB | 32'h01FF_8F80, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_0000);
        // R4 / R6 wrong funct3, funct7, opcode
        run_op("R4", 32'h2800_6033, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        run_op("R4", 32'h2A00_2033, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        run_op("R6", 32'h2800_4013, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        // R5 extension off
        run_op("R5", I_NIB,  1'b0, 64'h0123_4567_89AB_CDEF, 64'h0);
        run_op("R5", I_BYTE, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h0);

        // R7 idle cycle clears outputs
        @(negedge clk);
        check("R7", "idle valid",   {62'h0, v32, v64}, 64'h0);
        check("R7", "idle result",  r64 | {32'h0, r32}, 64'h0);
        check("R7", "idle illegal", {62'h0, il32, il64}, 64'h0);

        // R8 reset wins over a strobe
        @(negedge clk);
        insn = I_NIB; ext_en = 1'b1; a64 = 64'hFFFF_FFFF_FFFF_FFFF; b64 = '0;
        in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R8", "reset over strobe valid",  {62'h0, v32, v64}, 64'h0);
        check("R8", "reset over strobe result", r64 | {32'h0, r32}, 64'h0);
        in_valid = 1'b0; rst = 1'b0;

        // R1 back-to-back after reset
        run_op("R1", I_NIB, 1'b1, 64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF);
        finish_run();
    end
endmodule